// File: doc/BRIEF.md
# Radio-State GPIO Controller

This block controls two 16-bit banks of general-purpose pins, one serving the receive side of a radio and one serving the transmit side. Each bank has four registers: a software value, a direction mask, a source-select mask and a debug-mode mask. For every pin the block picks an output source. The source can be the software value, an entry from a radio-state table, or one of two debug buses coming from the surrounding fabric. This lets antenna switches and amplifier enables follow the radio as it moves between idle, transmit, receive and full duplex, without any software involvement.

Software reaches the registers over a simple 16-bit register bus. Every request is taken in the cycle it is presented. There is no back-pressure path. An acknowledge, together with any read data, returns one cycle after the request. The pad tristate buffers sit outside the block. Each bank brings out an output-enable vector and an output-value vector, and takes back the pad levels.

Top module: `rs_gpio_ctrl`

## Requirements
- R1: After reset every register holds zero, `bus_ack` is low, and all output-enable and output-value bits are low.
- R2: Register layout uses byte addresses, and address bit 4 selects the window.
  - When bit 4 is 0, the pin registers are decoded as: 0 rx value, 2 tx value, 4 rx direction, 6 tx direction, 8 rx select, 10 tx select, 12 rx debug-mode, 14 tx debug-mode.
  - When bit 4 is 1, the radio-state table is decoded as: 16 idle/rx, 18 idle/tx, 20 transmit-only/rx, 22 transmit-only/tx, 24 receive-only/rx, 26 receive-only/tx, 28 duplex/rx, 30 duplex/tx.
  - A read of any register other than the two value registers returns the last word written to it.
- R3: Address bit 0 is ignored, so an odd address reaches the same register as the even address below it.
- R4: A read of a bank's value register (address 0 or 2) returns that bank's pad levels as sampled on an earlier clock edge, not the written software value.
- R5: For a pin with debug-mode 0 and select 0, the output value is the matching bit of the bank's software value register.
- R6: For a pin with debug-mode 0 and select 1, the output value comes from the table entry for the current state and bank. The current state is {tx_active, rx_active}: 00 idle, 10 transmit-only, 01 receive-only, 11 duplex.
- R7: For a pin with debug-mode 1, select 0 takes the bit from `dbg_bus0` and select 1 takes it from `dbg_bus1`.
- R8: Each output-enable bit equals the bank's direction bit. A pin whose direction bit is 0 has output value 0, whatever its select and debug-mode bits are.
- R9: The pin outputs are registered. A change on `tx_active` or `rx_active` shows at the pins after exactly one rising clock edge. A register write shows on the pins one edge after it is stored.
- R10: `bus_ack` is high in exactly the cycle after each request cycle. For a read, `bus_rdata` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Access completed |
| tx_active | input | 1 | Transmitter active |
| rx_active | input | 1 | Receiver active |
| dbg_bus0 | input | 16 | First fabric debug bus |
| dbg_bus1 | input | 16 | Second fabric debug bus |
| rx_pins_in | input | 16 | Pad levels, rx bank |
| tx_pins_in | input | 16 | Pad levels, tx bank |
| rx_pins_oe | output | 16 | Output enables, rx bank |
| rx_pins_out | output | 16 | Output values, rx bank |
| tx_pins_oe | output | 16 | Output enables, tx bank |
| tx_pins_out | output | 16 | Output values, tx bank |

## Verification
The bench builds the block with its default parameters: 16-bit banks, a 5-bit byte address and four table states. With these values every register address, every state encoding and all four per-pin source combinations can be reached. The vector table mixes sources within a single word, so neighbouring pins must be steered independently. Directed tests then check the one-edge latency of a state change and check that odd addresses alias to the even address below them.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    RS_IDLE    = 2'b00,
    RS_RX_ONLY = 2'b01,
    RS_TX_ONLY = 2'b10,
    RS_FULL    = 2'b11
  } radio_state_e;

  typedef enum logic [1:0] {
    KIND_VALUE = 2'd0,
    KIND_DIR   = 2'd1,
    KIND_SEL   = 2'd2,
    KIND_DBG   = 2'd3
  } reg_kind_e;

  localparam int NUM_BANKS  = 2;
  localparam int NUM_STATES = 4;

  // Table slot order: idle, transmit-only, receive-only, duplex
  function automatic logic [1:0] state_slot(input radio_state_e st);
    case (st)
      RS_IDLE:    return 2'd0;
      RS_TX_ONLY: return 2'd1;
      RS_RX_ONLY: return 2'd2;
      default:    return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] sw_val,
  output logic [W-1:0] dir,
  output logic [W-1:0] sel,
  output logic [W-1:0] dbg,
  output logic [W-1:0] pin_samp
);
  import gpio_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_val <= '0;
      dir    <= '0;
      sel    <= '0;
      dbg    <= '0;
    end else if (wr_en) begin
      case (reg_kind_e'(wr_kind))
        KIND_VALUE: sw_val <= wdata;
        KIND_DIR:   dir    <= wdata;
        KIND_SEL:   sel    <= wdata;
        default:    dbg    <= wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_samp <= '0;
    else        pin_samp <= pin_in;
  end

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd1) |=> dir == $past(wdata)) else $error("dir write lost"); // R2

endmodule

// File: rtl/gpio_state_table.sv
module gpio_state_table #(
  parameter int W      = 16,
  parameter int STATES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_slot,
  input  logic                    wr_bank,
  input  logic [W-1:0]            wdata,
  input  logic [1:0]              rd_slot,
  input  logic                    rd_bank,
  output logic [W-1:0]            rd_data,
  input  gpio_pkg::radio_state_e  state,
  output logic [W-1:0]            cur_rx,
  output logic [W-1:0]            cur_tx
);
  import gpio_pkg::*;

  logic [W-1:0] ent [STATES][NUM_BANKS];
  logic [1:0]   cur_slot;

  generate
    for (genvar s = 0; s < STATES; s++) begin : g_slot
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            ent[s][k] <= '0;
          else if (wr_en && wr_slot == 2'(s) && wr_bank == 1'(k))
            ent[s][k] <= wdata;
        end
      end
    end
  endgenerate

  assign cur_slot = state_slot(state);
  assign rd_data  = ent[rd_slot][rd_bank];
  assign cur_rx   = ent[cur_slot][0];
  assign cur_tx   = ent[cur_slot][1];

  AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == rd_slot && wr_bank == rd_bank && $stable(rd_slot))
      |=> rd_data == $past(wdata)) else $error("table write lost"); // R2

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] dbg,
  input  logic [W-1:0] sw_val,
  input  logic [W-1:0] tbl_val,
  input  logic [W-1:0] dbg0,
  input  logic [W-1:0] dbg1,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out
);
  logic [W-1:0] nxt;

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic src;
      always_comb begin
        case ({dbg[b], sel[b]})
          2'b00:   src = sw_val[b];
          2'b01:   src = tbl_val[b];
          2'b10:   src = dbg0[b];
          default: src = dbg1[b];
        endcase
      end
      assign nxt[b] = dir[b] & src;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      pin_oe  <= dir;
      pin_out <= nxt;
    end
  end

  AST_INPUT_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0) else $error("input pin driven"); // R8
  AST_SW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out ^ $past(sw_val)) & $past(dir & ~dbg & ~sel)) == '0) else $error("sw path"); // R5
  AST_TABLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out ^ $past(tbl_val)) & $past(dir & ~dbg & sel)) == '0) else $error("table path"); // R6
  AST_DEBUG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out ^ $past(dbg1)) & $past(dir & dbg & sel)) == '0) else $error("debug path"); // R7

endmodule

// File: rtl/rs_gpio_ctrl.sv
module rs_gpio_ctrl #(
  parameter int W      = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_ack,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic [W-1:0]      dbg_bus0,
  input  logic [W-1:0]      dbg_bus1,
  input  logic [W-1:0]      rx_pins_in,
  input  logic [W-1:0]      tx_pins_in,
  output logic [W-1:0]      rx_pins_oe,
  output logic [W-1:0]      rx_pins_out,
  output logic [W-1:0]      tx_pins_oe,
  output logic [W-1:0]      tx_pins_out
);
  import gpio_pkg::*;

  localparam int WORD_W = 4;

  // Word address: byte bit 0 dropped, bit 3 of word = window
  logic [WORD_W-1:0] word_addr;
  logic              win_tbl;
  logic              idx_bank;
  logic [1:0]        idx_hi;
  logic              wr_cmd;

  assign word_addr = WORD_W'(bus_addr >> 1);
  assign win_tbl   = word_addr[3];
  assign idx_hi    = word_addr[2:1];
  assign idx_bank  = word_addr[0];
  assign wr_cmd    = bus_req & bus_we;

  radio_state_e state;
  assign state = radio_state_e'({tx_active, rx_active});

  logic [W-1:0] pin_in_a [NUM_BANKS];
  logic [W-1:0] sw_a     [NUM_BANKS];
  logic [W-1:0] dir_a    [NUM_BANKS];
  logic [W-1:0] sel_a    [NUM_BANKS];
  logic [W-1:0] dbg_a    [NUM_BANKS];
  logic [W-1:0] samp_a   [NUM_BANKS];
  logic [W-1:0] tbl_a    [NUM_BANKS];
  logic [W-1:0] oe_a     [NUM_BANKS];
  logic [W-1:0] out_a    [NUM_BANKS];

  assign pin_in_a[0] = rx_pins_in;
  assign pin_in_a[1] = tx_pins_in;

  logic [W-1:0] tbl_rd;

  gpio_state_table #(.W(W), .STATES(NUM_STATES)) i_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_cmd & win_tbl),
    .wr_slot (idx_hi),
    .wr_bank (idx_bank),
    .wdata   (bus_wdata),
    .rd_slot (idx_hi),
    .rd_bank (idx_bank),
    .rd_data (tbl_rd),
    .state   (state),
    .cur_rx  (tbl_a[0]),
    .cur_tx  (tbl_a[1])
  );

  generate
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      gpio_bank_regs #(.W(W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_cmd & ~win_tbl & (idx_bank == 1'(k))),
        .wr_kind  (idx_hi),
        .wdata    (bus_wdata),
        .pin_in   (pin_in_a[k]),
        .sw_val   (sw_a[k]),
        .dir      (dir_a[k]),
        .sel      (sel_a[k]),
        .dbg      (dbg_a[k]),
        .pin_samp (samp_a[k])
      );

      gpio_pin_mux #(.W(W)) i_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir     (dir_a[k]),
        .sel     (sel_a[k]),
        .dbg     (dbg_a[k]),
        .sw_val  (sw_a[k]),
        .tbl_val (tbl_a[k]),
        .dbg0    (dbg_bus0),
        .dbg1    (dbg_bus1),
        .pin_oe  (oe_a[k]),
        .pin_out (out_a[k])
      );
    end
  endgenerate

  assign rx_pins_oe  = oe_a[0];
  assign rx_pins_out = out_a[0];
  assign tx_pins_oe  = oe_a[1];
  assign tx_pins_out = out_a[1];

  // Read selection
  logic [W-1:0] rd_sel;
  always_comb begin
    if (win_tbl) begin
      rd_sel = tbl_rd;
    end else begin
      case (reg_kind_e'(idx_hi))
        KIND_VALUE: rd_sel = samp_a[idx_bank];
        KIND_DIR:   rd_sel = dir_a[idx_bank];
        KIND_SEL:   rd_sel = sel_a[idx_bank];
        default:    rd_sel = dbg_a[idx_bank];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= (bus_req && !bus_we) ? rd_sel : '0;
    end
  end

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack) else $error("missing ack"); // R10
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack) else $error("spurious ack"); // R10
  AST_STATE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a[0] == '1 && dbg_a[0] == '0 && dir_a[0] == '1 && $stable(sel_a[0]) && $stable(dir_a[0]))
      |=> rx_pins_out == $past(tbl_a[0])) else $error("state latency"); // R9

endmodule

// File: tb/test_rs_gpio_ctrl.sv
module test_rs_gpio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic        tx_active = 1'b0, rx_active = 1'b0;
  logic [15:0] dbg_bus0 = 16'h6A6A, dbg_bus1 = 16'h9C9C;
  logic [15:0] rx_pins_in = '0, tx_pins_in = '0;
  logic [15:0] rx_pins_oe, rx_pins_out, tx_pins_oe, tx_pins_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_gpio_ctrl i_rs_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .tx_active(tx_active), .rx_active(rx_active),
    .dbg_bus0(dbg_bus0), .dbg_bus1(dbg_bus1),
    .rx_pins_in(rx_pins_in), .tx_pins_in(tx_pins_in),
    .rx_pins_oe(rx_pins_oe), .rx_pins_out(rx_pins_out),
    .tx_pins_oe(tx_pins_oe), .tx_pins_out(tx_pins_out)
  );

  typedef struct packed {
    logic [1:0]  st;   // {tx_active, rx_active}
    logic [15:0] dir;
    logic [15:0] sel;
    logic [15:0] dbg;
    logic [15:0] sw;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 16'hFFFF, 16'h0000, 16'h0000, 16'hA5A5},
    '{2'b10, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
    '{2'b01, 16'hFF00, 16'hFFFF, 16'h0000, 16'hFFFF},
    '{2'b11, 16'hFFFF, 16'h00FF, 16'h0000, 16'h1234},
    '{2'b00, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF},
    '{2'b00, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000},
    '{2'b11, 16'h0F0F, 16'h3333, 16'h5555, 16'h9999},
    '{2'b00, 16'h0000, 16'hFFFF, 16'h00FF, 16'hFFFF}
  };

  // rx-bank table contents written by the bench, per state {tx,rx}
  function automatic logic [15:0] rx_tbl(input logic [1:0] st);
    case (st)
      2'b00:   return 16'h1E1E;
      2'b10:   return 16'h2D2D;
      2'b01:   return 16'h3C3C;
      default: return 16'h4B4B;
    endcase
  endfunction

  function automatic logic [15:0] expect_out(input vec_t v);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      if (!v.dir[b])                    r[b] = 1'b0;
      else if (!v.dbg[b] && !v.sel[b])  r[b] = v.sw[b];
      else if (!v.dbg[b])               r[b] = rx_tbl(v.st)[b];
      else if (!v.sel[b])               r[b] = dbg_bus0[b];
      else                              r[b] = dbg_bus1[b];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d, output logic ack);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; ack = bus_ack;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic ack;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 rx_oe", rx_pins_oe, 16'h0);
    check("R1 rx_out", rx_pins_out, 16'h0);
    check("R1 tx_oe", tx_pins_oe, 16'h0);
    check("R1 tx_out", tx_pins_out, 16'h0);
    check("R1 ack", {15'h0, bus_ack}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(5'd4, rd, ack);  check("R1 rx dir", rd, 16'h0);
    bus_read(5'd28, rd, ack); check("R1 table", rd, 16'h0);

    // R10: ack timing
    bus_read(5'd8, rd, ack);
    check("R10 ack after read", {15'h0, ack}, 16'h1);
    @(negedge clk);
    check("R10 ack drops", {15'h0, bus_ack}, 16'h0);

    // load table: rx entries, tx entries
    bus_write(5'd16, 16'h1E1E); bus_write(5'd18, 16'h5A5A);
    bus_write(5'd20, 16'h2D2D); bus_write(5'd22, 16'h6969);
    bus_write(5'd24, 16'h3C3C); bus_write(5'd26, 16'h7878);
    bus_write(5'd28, 16'h4B4B); bus_write(5'd30, 16'h8787);
    check("R10 ack after write", {15'h0, bus_ack}, 16'h1);

    // Vector table: R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      bus_write(5'd4, VECS[i].dir);
      bus_write(5'd8, VECS[i].sel);
      bus_write(5'd12, VECS[i].dbg);
      bus_write(5'd0, VECS[i].sw);
      tx_active = VECS[i].st[1];
      rx_active = VECS[i].st[0];
      settle();
      check("R8 oe follows dir", rx_pins_oe, VECS[i].dir);
      check("R5 R6 R7 R8 rx out", rx_pins_out, expect_out(VECS[i]));
    end

    // R6: tx bank, transmit-only state, mixed table and software
    bus_write(5'd6, 16'hFFFF);
    bus_write(5'd10, 16'hFF00);
    bus_write(5'd14, 16'h0000);
    bus_write(5'd2, 16'h00AA);
    tx_active = 1'b1; rx_active = 1'b0;
    settle();
    check("R6 tx bank table", tx_pins_out, 16'h69AA);

    // R9: state change latency, rx bank fully from table
    bus_write(5'd4, 16'hFFFF);
    bus_write(5'd8, 16'hFFFF);
    bus_write(5'd12, 16'h0000);
    tx_active = 1'b0; rx_active = 1'b0;
    settle();
    check("R9 before change", rx_pins_out, 16'h1E1E);
    tx_active = 1'b1;
    #1;
    check("R9 no combinational path", rx_pins_out, 16'h1E1E);
    @(negedge clk);
    check("R9 one edge later", rx_pins_out, 16'h2D2D);

    // R4: value register reads pad levels
    rx_pins_in = 16'hBEEF; tx_pins_in = 16'h1357;
    settle();
    bus_read(5'd0, rd, ack); check("R4 rx pads", rd, 16'hBEEF);
    bus_read(5'd2, rd, ack); check("R4 tx pads", rd, 16'h1357);

    // R3: bit 0 ignored
    bus_write(5'd5, 16'h00F0);
    bus_read(5'd4, rd, ack); check("R3 odd write", rd, 16'h00F0);
    bus_read(5'd5, rd, ack); check("R3 odd read", rd, 16'h00F0);

    // R2: readback of pin-config and table registers
    for (int a = 4; a < 32; a += 2) begin
      bus_write(5'(a), 16'hC000 + 16'(a));
    end
    for (int a = 4; a < 32; a += 2) begin
      bus_read(5'(a), rd, ack);
      check("R2 readback", rd, 16'hC000 + 16'(a));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule